// File: doc/BRIEF.md
# Pipelined Signed Multiply-Add

This block computes `a*b + c` for a continuous stream of signed operand triples. It accepts one triple on every clock and returns one result on every clock. The work is split over three register stages. The first stage captures the operands. The second stage forms the product. The third stage adds the addend. Because there is no backpressure, the block always takes its input and always presents its output.

The addend is supplied in the same cycle as its multiplicands. Inside the block it is held back one stage, so it reaches the adder together with its own product. A valid flag travels alongside the data, so bubbles in the input stream show up as bubbles at the output. The result is one bit wider than the product, so the sum is always exact.

Top module: `madd_pipe`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0. After reset is released, no result from before the reset ever appears at the output.
- R2: Every valid result equals a*b + c, computed exactly in two's complement. Operands are OP_W-bit signed and `result_o` is 2*OP_W+1 bits signed.
- R3: A triple captured at rising edge n is presented at the output after rising edge n+2. The first result of a stream is therefore visible after the third clock.
- R4: Back-to-back triples give one result per clock. Seven consecutive triples all complete within nine clocks of the first capture.
- R5: `out_valid_o` after edge n equals the `in_valid_i` captured at edge n-2. Input bubbles therefore appear as output bubbles at the same positions.
- R6: The extreme operands are exact with no overflow. (-2^(OP_W-1))^2 + (2^(OP_W-1)-1) and (-2^(OP_W-1))*(2^(OP_W-1)-1) - 2^(OP_W-1) both come out exactly.
- R7: Each addend is paired with the a and b presented in the same cycle, never with a neighbouring triple's product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears valid flags |
| in_valid_i | input | 1 | Qualifies a_i, b_i, c_i in this cycle |
| a_i | input | OP_W | Signed multiplicand |
| b_i | input | OP_W | Signed multiplier |
| c_i | input | OP_W | Signed addend, same cycle as a_i and b_i |
| out_valid_o | output | 1 | result_o holds a real result |
| result_o | output | 2*OP_W+1 | Signed a*b+c |

## Verification
The bench builds the block with the default OP_W of 16. At that width the most negative operand squared, and its product with the most positive, are directed cases whose exact values the bench can compute in 33-bit arithmetic. Random 16-bit triples with an independent addend in every cycle, mixed with random bubbles and a reset asserted in the middle of a stream, bring the addend-pairing delay and the valid-flag alignment within reach. A seven-triple burst checks both the three-clock fill and the nine-clock completion.

// File: rtl/madd_pkg.sv
package madd_pkg;
  localparam int unsigned DEF_OP_W = 16;

  function automatic int unsigned prod_width(input int unsigned op_w);
    return 2 * op_w;
  endfunction

  function automatic int unsigned res_width(input int unsigned op_w);
    return 2 * op_w + 1;
  endfunction
endpackage

// File: rtl/madd_operand_stage.sv
module madd_operand_stage #(
  parameter int unsigned OP_W = madd_pkg::DEF_OP_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [OP_W-1:0] a_i,
  input  logic signed [OP_W-1:0] b_i,
  input  logic signed [OP_W-1:0] c_i,
  output logic                   valid_o,
  output logic signed [OP_W-1:0] a_o,
  output logic signed [OP_W-1:0] b_o,
  output logic signed [OP_W-1:0] c_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // addend held one stage so it meets its product
  always_ff @(posedge clk_i) begin
    a_o <= a_i;
    b_o <= b_i;
    c_o <= c_i;
  end
endmodule

// File: rtl/madd_product_stage.sv
module madd_product_stage #(
  parameter int unsigned OP_W = madd_pkg::DEF_OP_W,
  localparam int unsigned PROD_W = madd_pkg::prod_width(OP_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [OP_W-1:0]   a_i,
  input  logic signed [OP_W-1:0]   b_i,
  input  logic signed [OP_W-1:0]   c_i,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] prod_o,
  output logic signed [OP_W-1:0]   c_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod_d;

  assign a_ext  = a_i;
  assign b_ext  = b_i;
  assign prod_d = a_ext * b_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    prod_o <= prod_d;
    c_o    <= c_i;
  end
endmodule

// File: rtl/madd_sum_stage.sv
module madd_sum_stage #(
  parameter int unsigned OP_W = madd_pkg::DEF_OP_W,
  localparam int unsigned PROD_W = madd_pkg::prod_width(OP_W),
  localparam int unsigned RES_W  = madd_pkg::res_width(OP_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic signed [OP_W-1:0]   c_i,
  output logic                     valid_o,
  output logic signed [RES_W-1:0]  sum_o
);
  logic signed [RES_W-1:0] prod_ext, c_ext;

  assign prod_ext = prod_i;
  assign c_ext    = c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    sum_o <= prod_ext + c_ext;
  end
endmodule

// File: rtl/madd_pipe.sv
module madd_pipe #(
  parameter int unsigned OP_W = madd_pkg::DEF_OP_W,
  localparam int unsigned PROD_W = madd_pkg::prod_width(OP_W),
  localparam int unsigned RES_W  = madd_pkg::res_width(OP_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [OP_W-1:0]  a_i,
  input  logic signed [OP_W-1:0]  b_i,
  input  logic signed [OP_W-1:0]  c_i,
  output logic                    out_valid_o,
  output logic signed [RES_W-1:0] result_o
);
  logic                     s1_valid, s2_valid;
  logic signed [OP_W-1:0]   s1_a, s1_b, s1_c, s2_c;
  logic signed [PROD_W-1:0] s2_prod;

  madd_operand_stage #(.OP_W(OP_W)) i_seg1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .valid_o(s1_valid),
    .a_o    (s1_a),
    .b_o    (s1_b),
    .c_o    (s1_c)
  );

  madd_product_stage #(.OP_W(OP_W)) i_seg2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s1_valid),
    .a_i    (s1_a),
    .b_i    (s1_b),
    .c_i    (s1_c),
    .valid_o(s2_valid),
    .prod_o (s2_prod),
    .c_o    (s2_c)
  );

  madd_sum_stage #(.OP_W(OP_W)) i_seg3 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s2_valid),
    .prod_i (s2_prod),
    .c_i    (s2_c),
    .valid_o(out_valid_o),
    .sum_o  (result_o)
  );
endmodule

// File: rtl/madd_pipe_chk.sv
module madd_pipe_chk #(
  parameter int unsigned OP_W = madd_pkg::DEF_OP_W,
  localparam int unsigned RES_W = madd_pkg::res_width(OP_W)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic signed [OP_W-1:0]  a_i,
  input logic signed [OP_W-1:0]  b_i,
  input logic signed [OP_W-1:0]  c_i,
  input logic                    out_valid_o,
  input logic signed [RES_W-1:0] result_o
);
  logic [1:0] age_q;
  logic       v1_q, v2_q, v3_q;
  logic signed [OP_W-1:0]  a_h [3];
  logic signed [OP_W-1:0]  b_h [3];
  logic signed [OP_W-1:0]  c_h [3];
  logic signed [RES_W-1:0] a_x, b_x, c_x, exp_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      v1_q <= in_valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk_i) begin
    a_h[0] <= a_i;    b_h[0] <= b_i;    c_h[0] <= c_i;
    a_h[1] <= a_h[0]; b_h[1] <= b_h[0]; c_h[1] <= c_h[0];
    a_h[2] <= a_h[1]; b_h[2] <= b_h[1]; c_h[2] <= c_h[1];
  end

  assign a_x     = a_h[2];
  assign b_x     = b_h[2];
  assign c_x     = c_h[2];
  assign exp_res = a_x * b_x + c_x;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!out_valid_o);
  end

  // R5
  valid_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (out_valid_o == v3_q));

  // R1
  no_stale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd3) |-> !out_valid_o);

  // R2
  result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && v3_q) |-> (result_o == exp_res));

  // R4
  stream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && v2_q && v3_q) |=> out_valid_o);
endmodule

bind madd_pipe madd_pipe_chk #(.OP_W(OP_W)) i_madd_pipe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .c_i        (c_i),
  .out_valid_o(out_valid_o),
  .result_o   (result_o)
);

// File: tb/test_madd_pipe.sv
`timescale 1ns/1ps
module test_madd_pipe;
  localparam int OP_W  = 16;
  localparam int RES_W = 2 * OP_W + 1;
  localparam int DEPTH = 2048;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic signed [OP_W-1:0]  a = '0, b = '0, c = '0;
  logic                    out_valid;
  logic signed [RES_W-1:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  int edge_n = 0;
  int last_rst_edge = 0;
  logic                    v_log [DEPTH];
  logic signed [RES_W-1:0] r_log [DEPTH];
  logic                    done = 1'b0;

  always #5 clk = ~clk;

  madd_pipe #(.OP_W(OP_W)) i_madd_pipe (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .a_i        (a),
    .b_i        (b),
    .c_i        (c),
    .out_valid_o(out_valid),
    .result_o   (result)
  );

  function automatic logic signed [RES_W-1:0] ref_madd(
      input logic signed [OP_W-1:0] x, input logic signed [OP_W-1:0] y,
      input logic signed [OP_W-1:0] z);
    logic signed [RES_W-1:0] xe, ye, ze;
    xe = x; ye = y; ze = z;
    return xe * ye + ze;
  endfunction

  task automatic check(input string req, input logic [RES_W-1:0] act,
                       input logic [RES_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", req, act, exp, edge_n);
    end
  endtask

  // drive one cycle, capture at posedge, check outputs at the following negedge
  task automatic step(input logic v, input logic signed [OP_W-1:0] x,
                      input logic signed [OP_W-1:0] y, input logic signed [OP_W-1:0] z);
    int src;
    in_valid = v; a = x; b = y; c = z;
    @(posedge clk);
    edge_n++;
    if (edge_n < DEPTH) begin
      v_log[edge_n] = v && rst_n;
      r_log[edge_n] = ref_madd(x, y, z);
    end
    @(negedge clk);
    src = edge_n - 2;
    if (!rst_n) begin
      last_rst_edge = edge_n;
      check("R1", RES_W'(out_valid), '0);
    end else if (src > last_rst_edge && src < DEPTH) begin
      check("R5", RES_W'(out_valid), RES_W'(v_log[src]));
      if (v_log[src] && out_valid) check("R2", result, r_log[src]);
    end else begin
      check("R1", RES_W'(out_valid), '0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int start, first_out, cnt;
    logic signed [OP_W-1:0] mn, mx;
    void'($urandom(32'h5eed_1234));
    mn = {1'b1, {(OP_W-1){1'b0}}};
    mx = {1'b0, {(OP_W-1){1'b1}}};

    // R1: reset state
    repeat (3) step(1'b1, 16'sd3, 16'sd4, 16'sd5);
    rst_n = 1'b1;

    // R3 R4: seven back-to-back triples, then bubbles
    start = edge_n;
    first_out = -1;
    cnt = 0;
    for (int i = 1; i <= 7; i++) begin
      step(1'b1, OP_W'(i), OP_W'(i + 1), OP_W'(10 * i));
      if (out_valid) begin cnt++; if (first_out < 0) first_out = edge_n - start; end
    end
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, '0, '0);
      if (out_valid && edge_n - start <= 9) begin
        cnt++; if (first_out < 0) first_out = edge_n - start;
      end
      if (edge_n - start == 9) check("R4", result, ref_madd(16'sd7, 16'sd8, 16'sd70));
    end
    check("R3", RES_W'(first_out), RES_W'(3));
    check("R4", RES_W'(cnt), RES_W'(7));

    // R6: extremes
    step(1'b1, mn, mn, mx);
    step(1'b1, mn, mx, mn);
    step(1'b1, mx, mx, mx);
    step(1'b1, mn, mn, mn);
    repeat (3) step(1'b0, '0, '0, '0);
    check("R6", ref_madd(mn, mn, mx), RES_W'(33'sd1073774591));
    check("R6", ref_madd(mn, mx, mn), -RES_W'(33'sd1073741824));

    // R7: fixed product, changing addend each cycle
    for (int i = 0; i < 6; i++) step(1'b1, 16'sd100, -16'sd7, OP_W'(i * 1000 - 2500));
    repeat (3) step(1'b0, '0, '0, '0);

    // R2 R5 R7: random stream with bubbles
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, OP_W'($urandom), OP_W'($urandom), OP_W'($urandom));

    // R1: reset in mid-stream, nothing stale afterwards
    rst_n = 1'b0;
    step(1'b1, 16'sd1, 16'sd1, 16'sd1);
    step(1'b1, 16'sd2, 16'sd2, 16'sd2);
    rst_n = 1'b1;
    for (int i = 0; i < 50; i++)
      step(($urandom % 3) != 0, OP_W'($urandom), OP_W'($urandom), OP_W'($urandom));
    repeat (3) step(1'b0, '0, '0, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule